// File: doc/BRIEF.md
# Boundary-Scan Instruction and Data Registers

This block holds the instruction register and the data registers of an IEEE 1149.1 test port. A separate TAP state machine decodes its states and passes them in as level strobes. Each strobe is acted on at the rising TCK edge that ends the state it stands for. The block shifts serial data between TDI and TDO and keeps the active instruction. It selects one of three data registers: a one-bit bypass stage, a 32-bit identity word, or a boundary register that covers a small set of input and output pins.

The boundary register has `NIN + 2*NOUT` cells. Bits `[NIN-1:0]` sample the input pins. Bits `[NIN+NOUT-1:NIN]` hold the output pin values. Bits `[NIN+2*NOUT-1:NIN+NOUT]` hold the output enables. Bit 0 is the cell nearest to TDO. Every cell has a shift stage and a separate update latch. Depending on the active instruction, the output pins carry one of three things: the functional core's values, the update latches, or a forced high-impedance state.

The identity word is assembled from two parameters and a fixed manufacturer field.

Top module: `scan_instr_regs`

## Requirements
- R1: After asynchronous reset, or after any cycle with `stTlr` high, the active instruction is IDCODE (code 100). A data scan with no instruction scan before it returns the identity word, and the pins follow the core.
- R2: The identity word has bit 0 = 1, bits 11:1 = 00010100001, bits 27:12 = `DEV_ID` and bits 31:28 = `VERSION`. It is loaded at Capture-DR and leaves on TDO least significant bit first.
- R3: The instruction register is 3 bits wide. The codes are EXTEST 000, SAMPLE 010, HIGH-Z 011, IDCODE 100, CLAMP 101 and BYPASS 111, and any other code acts as BYPASS. Capture-IR loads 001, so the first three Shift-IR bits on TDO are 1, 0, 0.
- R4: A newly shifted instruction changes nothing at the pins until Update-IR.
- R5: Under BYPASS, Capture-DR clears the bypass stage. Shift-DR then delays TDI by one cycle, so the first bit out is 0.
- R6: SAMPLE captures `{padOe, padOut, pinIn}` at Capture-DR. The pins keep following the core, even after Update-DR.
- R7: Once Update-IR has made EXTEST active, the output pins take their value and enable from the update latches. Capture-DR samples the input pins and the driven outputs.
- R8: The update latches load from the shift stages only at Update-DR, and only under SAMPLE or EXTEST. Shift-DR leaves the driven pins untouched.
- R9: Under HIGH-Z, every `padOe` bit is 0 and the bypass stage is the scan path.
- R10: Under CLAMP, the pins carry the update latches and the bypass stage is the scan path. The pins hold steady for as long as CLAMP stays active, even through core changes and complete data scans.
- R11: TDO and `tdoEn` update on the falling TCK edge. `tdoEn` is 1 only for cycles spent in Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stTlr | input | 1 | TAP is in Test-Logic-Reset |
| stCapIr | input | 1 | TAP is in Capture-IR |
| stShIr | input | 1 | TAP is in Shift-IR |
| stUpdIr | input | 1 | TAP is in Update-IR |
| stCapDr | input | 1 | TAP is in Capture-DR |
| stShDr | input | 1 | TAP is in Shift-DR |
| stUpdDr | input | 1 | TAP is in Update-DR |
| tdi | input | 1 | Serial test data in |
| pinIn | input | NIN | Values present at the input pins |
| coreOut | input | NOUT | Output values from the functional core |
| coreOe | input | NOUT | Output enables from the functional core |
| padOut | output | NOUT | Output values sent to the pads |
| padOe | output | NOUT | Output enables sent to the pads |
| tdo | output | 1 | Serial test data out |
| tdoEn | output | 1 | TDO carries valid data |

## Verification
The assertions assume that at most one TAP strobe is high in any cycle. They also assume that the strobes follow a legal TAP walk: capture comes before shift, and an exit cycle lies between shift and update. The bench drives only such walks, through tasks that set one strobe per cycle a quarter period after the rising edge. It holds every strobe low during reset. The core-side inputs change only between scans, so the steadiness checks for CLAMP and for latch hold are tested against deliberate core changes.

// File: rtl/jtagScanPkg.sv
package jtagScanPkg;

  localparam int IR_W = 3;

  typedef enum logic [IR_W-1:0] {
    INS_EXTEST = 3'b000,
    INS_SAMPLE = 3'b010,
    INS_HIGHZ  = 3'b011,
    INS_IDCODE = 3'b100,
    INS_CLAMP  = 3'b101,
    INS_BYPASS = 3'b111
  } insCode_e;

  localparam logic [10:0] MFR_CODE = 11'b00010100001;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic capBsr;
    logic shBsr;
    logic updBsr;
    logic capId;
    logic shId;
    logic capByp;
    logic shByp;
    logic selBsr;
    logic selId;
    logic pinsFromLatch;
    logic pinsHiZ;
    logic irShifting;
    logic irOut;
    logic drShifting;
  } dpCtl_t;

endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import jtagScanPkg::*;
(
  input  logic   tck,
  input  logic   rstN,
  input  logic   stTlr,
  input  logic   stCapIr,
  input  logic   stShIr,
  input  logic   stUpdIr,
  input  logic   stCapDr,
  input  logic   stShDr,
  input  logic   stUpdDr,
  input  logic   tdi,
  output dpCtl_t ctl
);

  logic [IR_W-1:0] irShift;
  logic [IR_W-1:0] irActive;
  logic isBsr, isId, isByp, isExtest, isClamp, isHiZ;

  // instruction shift stage
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)        irShift <= '0;
    else if (stCapIr) irShift <= {{(IR_W-2){1'b0}}, 2'b01};
    else if (stShIr)  irShift <= {tdi, irShift[IR_W-1:1]};
  end

  // parallel instruction latch, IDCODE on reset
  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)        irActive <= INS_IDCODE;
    else if (stTlr)   irActive <= INS_IDCODE;
    else if (stUpdIr) irActive <= irShift;
  end

  always_comb begin
    isExtest = (irActive == INS_EXTEST);
    isClamp  = (irActive == INS_CLAMP);
    isHiZ    = (irActive == INS_HIGHZ);
    isBsr    = isExtest || (irActive == INS_SAMPLE);
    isId     = (irActive == INS_IDCODE);
    isByp    = !isBsr && !isId;

    ctl.capBsr        = stCapDr && isBsr;
    ctl.shBsr         = stShDr  && isBsr;
    ctl.updBsr        = stUpdDr && isBsr;
    ctl.capId         = stCapDr && isId;
    ctl.shId          = stShDr  && isId;
    ctl.capByp        = stCapDr && isByp;
    ctl.shByp         = stShDr  && isByp;
    ctl.selBsr        = isBsr;
    ctl.selId         = isId;
    ctl.pinsFromLatch = isExtest || isClamp;
    ctl.pinsHiZ       = isHiZ;
    ctl.irShifting    = stShIr;
    ctl.irOut         = irShift[0];
    ctl.drShifting    = stShDr;
  end

  // R1: Test-Logic-Reset forces IDCODE
  assert_tlr_idcode_R1: assert property (@(posedge tck) disable iff (!rstN)
    stTlr |=> (irActive == INS_IDCODE));

  // R3: capture pattern in the low instruction bits
  assert_capir_pattern_R3: assert property (@(posedge tck) disable iff (!rstN)
    stCapIr |=> (irShift[1:0] == 2'b01));

  // R4: instruction changes only on Update-IR or reset state
  assert_instr_hold_R4: assert property (@(posedge tck) disable iff (!rstN)
    (!stUpdIr && !stTlr) |=> $stable(irActive));

endmodule

// File: rtl/scan_dpath.sv
module scan_dpath
  import jtagScanPkg::*;
#(
  parameter int          NIN     = 4,
  parameter int          NOUT    = 4,
  parameter logic [15:0] DEV_ID  = 16'h0001,
  parameter logic [3:0]  VERSION = 4'h0
) (
  input  logic            tck,
  input  logic            rstN,
  input  dpCtl_t          ctl,
  input  logic            tdi,
  input  logic [NIN-1:0]  pinIn,
  input  logic [NOUT-1:0] coreOut,
  input  logic [NOUT-1:0] coreOe,
  output logic [NOUT-1:0] padOut,
  output logic [NOUT-1:0] padOe,
  output logic            tdo,
  output logic            tdoEn
);

  localparam int BSR_LEN = NIN + 2 * NOUT;
  localparam int OV_LO   = NIN;
  localparam int OE_LO   = NIN + NOUT;
  localparam logic [31:0] ID_WORD = {VERSION, DEV_ID, MFR_CODE, 1'b1};

  logic               bypReg;
  logic [31:0]        idReg;
  logic [BSR_LEN-1:0] bsrShift;
  logic [BSR_LEN-1:0] bsrUpd;
  logic [BSR_LEN-1:0] bsrCapt;
  logic               tdoNext;
  logic               clampNow;

  assign bsrCapt  = {padOe, padOut, pinIn};
  assign clampNow = ctl.pinsFromLatch && !ctl.selBsr;

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)           bypReg <= 1'b0;
    else if (ctl.capByp) bypReg <= 1'b0;
    else if (ctl.shByp)  bypReg <= tdi;
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)          idReg <= ID_WORD;
    else if (ctl.capId) idReg <= ID_WORD;
    else if (ctl.shId)  idReg <= {tdi, idReg[31:1]};
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)           bsrShift <= '0;
    else if (ctl.capBsr) bsrShift <= bsrCapt;
    else if (ctl.shBsr)  bsrShift <= {tdi, bsrShift[BSR_LEN-1:1]};
  end

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)           bsrUpd <= '0;
    else if (ctl.updBsr) bsrUpd <= bsrShift;
  end

  // per-pin override muxes
  for (genvar g = 0; g < NOUT; g++) begin : gPin
    assign padOut[g] = ctl.pinsHiZ       ? coreOut[g] :
                       ctl.pinsFromLatch ? bsrUpd[OV_LO + g] : coreOut[g];
    assign padOe[g]  = ctl.pinsHiZ       ? 1'b0 :
                       ctl.pinsFromLatch ? bsrUpd[OE_LO + g] : coreOe[g];
  end

  always_comb begin
    if (ctl.irShifting)  tdoNext = ctl.irOut;
    else if (ctl.selBsr) tdoNext = bsrShift[0];
    else if (ctl.selId)  tdoNext = idReg[0];
    else                 tdoNext = bypReg;
  end

  always_ff @(negedge tck or negedge rstN) begin
    if (!rstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdo   <= tdoNext;
      tdoEn <= ctl.irShifting || ctl.drShifting;
    end
  end

  // R2: capture loads the identity word
  assert_id_capture_R2: assert property (@(posedge tck) disable iff (!rstN)
    ctl.capId |=> (idReg[0] && idReg[11:1] == MFR_CODE && idReg[27:12] == DEV_ID
                   && idReg[31:28] == VERSION));

  // R5: bypass stage delays TDI by one cycle
  assert_bypass_delay_R5: assert property (@(posedge tck) disable iff (!rstN)
    ctl.shByp |=> (bypReg == $past(tdi)));

  // R8: update latches hold outside Update-DR
  assert_latch_hold_R8: assert property (@(posedge tck) disable iff (!rstN)
    !ctl.updBsr |=> $stable(bsrUpd));

  // R10: pins frozen while clamp stays active
  assert_clamp_steady_R10: assert property (@(posedge tck) disable iff (!rstN)
    clampNow |=> (!clampNow || ($stable(padOut) && $stable(padOe))));

endmodule

// File: rtl/scan_instr_regs.sv
module scan_instr_regs
  import jtagScanPkg::*;
#(
  parameter int          NIN     = 4,
  parameter int          NOUT    = 4,
  parameter logic [15:0] DEV_ID  = 16'h0001,
  parameter logic [3:0]  VERSION = 4'h0
) (
  input  logic            tck,
  input  logic            rstN,
  input  logic            stTlr,
  input  logic            stCapIr,
  input  logic            stShIr,
  input  logic            stUpdIr,
  input  logic            stCapDr,
  input  logic            stShDr,
  input  logic            stUpdDr,
  input  logic            tdi,
  input  logic [NIN-1:0]  pinIn,
  input  logic [NOUT-1:0] coreOut,
  input  logic [NOUT-1:0] coreOe,
  output logic [NOUT-1:0] padOut,
  output logic [NOUT-1:0] padOe,
  output logic            tdo,
  output logic            tdoEn
);

  dpCtl_t ctl;

  scan_ctrl uCtrl (
    .tck     (tck),
    .rstN    (rstN),
    .stTlr   (stTlr),
    .stCapIr (stCapIr),
    .stShIr  (stShIr),
    .stUpdIr (stUpdIr),
    .stCapDr (stCapDr),
    .stShDr  (stShDr),
    .stUpdDr (stUpdDr),
    .tdi     (tdi),
    .ctl     (ctl)
  );

  scan_dpath #(
    .NIN     (NIN),
    .NOUT    (NOUT),
    .DEV_ID  (DEV_ID),
    .VERSION (VERSION)
  ) uDpath (
    .tck     (tck),
    .rstN    (rstN),
    .ctl     (ctl),
    .tdi     (tdi),
    .pinIn   (pinIn),
    .coreOut (coreOut),
    .coreOe  (coreOe),
    .padOut  (padOut),
    .padOe   (padOe),
    .tdo     (tdo),
    .tdoEn   (tdoEn)
  );

endmodule

// File: tb/sim_scan_instr_regs.sv
module sim_scan_instr_regs;

  localparam int NIN  = 4;
  localparam int NOUT = 4;
  localparam logic [31:0] ID_EXP = {4'h0, 16'h0001, 11'b00010100001, 1'b1};

  localparam logic [6:0] S_IDLE  = 7'b0000000;
  localparam logic [6:0] S_TLR   = 7'b1000000;
  localparam logic [6:0] S_CAPIR = 7'b0100000;
  localparam logic [6:0] S_SHIR  = 7'b0010000;
  localparam logic [6:0] S_UPDIR = 7'b0001000;
  localparam logic [6:0] S_CAPDR = 7'b0000100;
  localparam logic [6:0] S_SHDR  = 7'b0000010;
  localparam logic [6:0] S_UPDDR = 7'b0000001;

  logic tck = 1'b0;
  logic rstN;
  logic stTlr, stCapIr, stShIr, stUpdIr, stCapDr, stShDr, stUpdDr;
  logic tdi;
  logic [NIN-1:0]  pinIn;
  logic [NOUT-1:0] coreOut, coreOe, padOut, padOe;
  logic tdo, tdoEn;

  int nCmp = 0;
  int nBad = 0;
  bit finished = 0;

  typedef struct {
    string req;
    logic  bitv;
  } expItem_t;
  expItem_t expQ[$];

  always #10 tck = ~tck;

  scan_instr_regs #(.NIN(NIN), .NOUT(NOUT), .DEV_ID(16'h0001), .VERSION(4'h0)) u0 (
    .tck(tck), .rstN(rstN), .stTlr(stTlr), .stCapIr(stCapIr), .stShIr(stShIr),
    .stUpdIr(stUpdIr), .stCapDr(stCapDr), .stShDr(stShDr), .stUpdDr(stUpdDr),
    .tdi(tdi), .pinIn(pinIn), .coreOut(coreOut), .coreOe(coreOe),
    .padOut(padOut), .padOe(padOe), .tdo(tdo), .tdoEn(tdoEn)
  );

  // monitor: pops one expected bit for every enabled TDO cycle
  always @(posedge tck) begin
    expItem_t it;
    if (rstN && tdoEn && !finished) begin
      nCmp++;
      if (expQ.size() == 0) begin
        nBad++;
        $display("FAIL R11: tdo enabled with nothing expected, tdo=%0b expected none", tdo);
      end else begin
        it = expQ.pop_front();
        if (tdo !== it.bitv) begin
          nBad++;
          $display("FAIL %s: tdo=%0b expected %0b", it.req, tdo, it.bitv);
        end
      end
    end
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] st, input logic d);
    {stTlr, stCapIr, stShIr, stUpdIr, stCapDr, stShDr, stUpdDr} = st;
    tdi = d;
    @(posedge tck);
    #5;
  endtask

  // Capture-IR and three Shift-IR cycles, no update yet
  task automatic irLoad(input logic [2:0] code);
    drive(S_CAPIR, 1'b0);
    expQ.push_back('{"R3", 1'b1});
    expQ.push_back('{"R3", 1'b0});
    expQ.push_back('{"R3", 1'b0});
    for (int i = 0; i < 3; i++) begin
      if (i == 0) begin
        {stTlr, stCapIr, stShIr, stUpdIr, stCapDr, stShDr, stUpdDr} = S_SHIR;
        tdi = code[0];
        check("R11 before falling edge", {31'd0, tdoEn}, 32'd0);
        #10;
        check("R11 after falling edge", {31'd0, tdoEn}, 32'd1);
        @(posedge tck);
        #5;
      end else begin
        drive(S_SHIR, code[i]);
      end
    end
    drive(S_IDLE, 1'b0);
  endtask

  task automatic irUpdate();
    drive(S_UPDIR, 1'b0);
    drive(S_IDLE, 1'b0);
  endtask

  task automatic drCapShift(input int n, input logic [63:0] din,
                            input logic [63:0] expOut, input string req);
    drive(S_CAPDR, 1'b0);
    for (int i = 0; i < n; i++) begin
      expQ.push_back('{req, expOut[i]});
      drive(S_SHDR, din[i]);
    end
    drive(S_IDLE, 1'b0);
    check("R11 idle after shift", {31'd0, tdoEn}, 32'd0);
  endtask

  task automatic drUpdate();
    drive(S_UPDDR, 1'b0);
    drive(S_IDLE, 1'b0);
  endtask

  initial begin
    #(20 * 200000);
    nBad++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    finishRun();
  end

  initial begin
    logic [63:0] d;
    rstN = 1'b0;
    {stTlr, stCapIr, stShIr, stUpdIr, stCapDr, stShDr, stUpdDr} = S_IDLE;
    tdi = 1'b0;
    pinIn = 4'hA; coreOut = 4'h5; coreOe = 4'hC;
    repeat (3) @(posedge tck);
    #5;
    rstN = 1'b1;

    // reset state
    check("R11 reset tdoEn", {31'd0, tdoEn}, 32'd0);
    check("R1 reset padOut", {28'd0, padOut}, {28'd0, coreOut});
    check("R1 reset padOe", {28'd0, padOe}, {28'd0, coreOe});

    // identity word with default instruction
    drCapShift(32, 64'd0, {32'd0, ID_EXP}, "R1/R2");

    // bypass
    irLoad(3'b111); irUpdate();
    d = 64'hB2;
    drCapShift(8, d, {d[62:0], 1'b0}, "R5");

    // unused code acts as bypass
    irLoad(3'b110); irUpdate();
    d = 64'h13;
    drCapShift(5, d, {d[62:0], 1'b0}, "R3");

    // Test-Logic-Reset restores IDCODE
    drive(S_TLR, 1'b0);
    drive(S_IDLE, 1'b0);
    drCapShift(32, 64'hFFFF_FFFF, {32'd0, ID_EXP}, "R1");

    // SAMPLE with preload
    irLoad(3'b010); irUpdate();
    pinIn = 4'h6; coreOut = 4'h9; coreOe = 4'h3;
    #1;
    drCapShift(12, 64'h5A3, 64'h396, "R6");
    check("R6 pins untouched padOut", {28'd0, padOut}, 32'h9);
    drUpdate();
    check("R6 after update padOut", {28'd0, padOut}, 32'h9);
    check("R6 after update padOe", {28'd0, padOe}, 32'h3);

    // EXTEST: no effect before Update-IR
    irLoad(3'b000);
    check("R4 pre-update padOut", {28'd0, padOut}, 32'h9);
    check("R4 pre-update padOe", {28'd0, padOe}, 32'h3);
    irUpdate();
    check("R7 extest padOut", {28'd0, padOut}, 32'hA);
    check("R7 extest padOe", {28'd0, padOe}, 32'h5);

    // EXTEST capture and shift without disturbing pins
    drCapShift(12, 64'h3C0, 64'h5A6, "R7");
    check("R8 pins during shift padOut", {28'd0, padOut}, 32'hA);
    check("R8 pins during shift padOe", {28'd0, padOe}, 32'h5);
    drUpdate();
    check("R8 after update padOut", {28'd0, padOut}, 32'hC);
    check("R8 after update padOe", {28'd0, padOe}, 32'h3);

    // HIGH-Z
    irLoad(3'b011); irUpdate();
    check("R9 highz padOe", {28'd0, padOe}, 32'h0);
    d = 64'h6;
    drCapShift(4, d, {d[62:0], 1'b0}, "R9");
    drUpdate();
    check("R9 highz after update padOe", {28'd0, padOe}, 32'h0);

    // CLAMP
    irLoad(3'b101); irUpdate();
    check("R10 clamp padOut", {28'd0, padOut}, 32'hC);
    check("R10 clamp padOe", {28'd0, padOe}, 32'h3);
    coreOut = 4'h0; coreOe = 4'hF;
    d = 64'h3F;
    drCapShift(6, d, {d[62:0], 1'b0}, "R10");
    drUpdate();
    check("R10 clamp held padOut", {28'd0, padOut}, 32'hC);
    check("R10 clamp held padOe", {28'd0, padOe}, 32'h3);

    repeat (2) drive(S_IDLE, 1'b0);
    check("R11 all expected bits seen", expQ.size(), 32'd0);
    finishRun();
  end

endmodule